// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

The block holds a small set of recent page translations. Each cycle it can take one lookup: the page-number part of the incoming virtual address is compared with the tag of every valid entry at the same time. The frame number of the matching entry is selected and placed in front of the page offset, which passes through unchanged, to form the physical address. The read or write request is also checked against the entry's permission bits, so each lookup ends as a hit, a miss or a protection fault. Lookup results are combinational. The entry state changes at the next rising clock edge.

Each entry records whether it has been touched since software last cleared the touch marks, and whether a write has modified its page. Software installs a translation through a fill port after a miss. The block chooses where the new translation goes. While the fill request is held, the block reports the victim slot and, if that slot held a live translation, its page number and whether it was modified, so that a write-back can be scheduled. A flush input drops every translation, and a touch-clear input wipes all the touch marks to start a new recency window.

Top module: `tlb_xlate`

## Requirements
- R1: On a lookup whose page number equals the tag of a valid entry, and whose access type is permitted, `lk_hit` is 1 and `lk_paddr` equals the entry's frame number concatenated above the unchanged low OFS_W offset bits of `lk_vaddr`.
- R2: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is 1, and `lk_miss` is 1 when no valid entry matches. With `lk_valid` low, all three are 0.
- R3: Permission field `fill_prot` uses bit 0 for read allowed and bit 1 for write allowed (`lk_write` = 1 means write). A matching lookup whose access type lacks its permission bit gives `lk_fault` = 1 and `lk_hit` = 0.
- R4: A faulting lookup leaves the entry's modified and touched marks unchanged.
- R5: A write hit sets the entry's modified mark. A fill clears it.
- R6: A hit, read or write, sets the entry's touched mark. A fill also sets it.
- R7: `use_clear` clears every touched mark at the next edge. If a hit happens in the same cycle, the hit entry keeps its mark.
- R8: The victim `fill_victim` is the lowest-indexed invalid entry. If there is none, it is the lowest-indexed entry whose touched mark is clear. Otherwise it is entry 0.
- R9: `flush` invalidates every entry at the next edge. A lookup in the following cycle misses.
- R10: A fill writes tag, frame number and permissions into the victim slot, and the new entry is valid in the next cycle. A fill in the same cycle as `flush` survives the flush.
- R11: While `fill_valid` is high, `evict_valid` shows whether the victim slot held a valid entry, `evict_vpn` shows its tag, and `evict_dirty` shows its modified mark. With `fill_valid` low, `evict_valid` and `evict_dirty` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address |
| lk_hit | output | 1 | Permitted match |
| lk_miss | output | 1 | No valid match |
| lk_fault | output | 1 | Match, access not permitted |
| lk_paddr | output | PFN_W+OFS_W | Physical address, meaningful on hit |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_prot | input | 2 | Permissions: bit0 read, bit1 write |
| fill_victim | output | $clog2(ENTRIES) | Slot the fill will use |
| evict_valid | output | 1 | Victim slot holds a live entry |
| evict_dirty | output | 1 | Live victim has been modified |
| evict_vpn | output | VPN_W | Tag of the victim slot |
| flush | input | 1 | Invalidate all entries |
| use_clear | input | 1 | Clear all touched marks |

## Verification
The hazardous overlap is a touch-clear that arrives in the same cycle as a hit. The bench fills every slot so that all entries are touched, then asserts `use_clear` together with a read hit on entry 0. It judges the outcome at the fill port alone: a probing fill must name entry 1, not entry 0, as the victim. A second overlap, a flush arriving together with a fill, is judged by a hit on the newly filled page and a miss on every older page.

// File: rtl/tlb_pkg.sv
// Shared types for the translation cache.
// Assumes: permission field is two bits, read-allowed in bit 0, write-allowed in bit 1.
package tlb_pkg;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } tlb_prot_t;

    localparam int PROT_W = $bits(tlb_prot_t);

    // Returns whether the access type is allowed by the permission field.
    function automatic logic tlb_permits(input tlb_prot_t prot, input logic is_write);
        return is_write ? prot.wr_ok : prot.rd_ok;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag comparator: one equality comparator per entry, qualified by valid.
// Assumes: tags are packed entry-major into tags_flat; at most one valid entry
// holds any tag (software fills only after a miss).
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES*VPN_W-1:0] tags_flat,
    input  logic [ENTRIES-1:0]       valid,
    input  logic [VPN_W-1:0]         key,
    output logic [ENTRIES-1:0]       match
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Compare one entry's tag with the key.
        assign match[g] = valid[g] && (tags_flat[g*VPN_W +: VPN_W] == key);
    end

endmodule

// File: rtl/tlb_onehot_mux.sv
// AND-OR multiplexer driven by a one-hot (or all-zero) select vector.
// Assumes: sel has at most one bit set; an all-zero select yields zero.
module tlb_onehot_mux #(
    parameter int ENTRIES = 16,
    parameter int W       = 20
) (
    input  logic [ENTRIES*W-1:0] data_flat,
    input  logic [ENTRIES-1:0]   sel,
    output logic [W-1:0]         dout
);

    // OR together every selected slice.
    always_comb begin
        dout = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel[i]) dout = dout | data_flat[i*W +: W];
        end
    end

endmodule

// File: rtl/tlb_victim.sv
// Replacement selector: lowest invalid slot, else lowest untouched slot, else slot 0.
// Assumes: ENTRIES >= 2.
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] used,
    output logic [IDX_W-1:0]   victim
);

    logic [IDX_W-1:0] inv_idx;
    logic [IDX_W-1:0] cold_idx;
    logic             inv_any;
    logic             cold_any;

    // Priority encoders scanning from the top so the lowest index wins.
    always_comb begin
        inv_idx  = '0;
        cold_idx = '0;
        inv_any  = 1'b0;
        cold_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                inv_idx = IDX_W'(i);
                inv_any = 1'b1;
            end
            if (!used[i]) begin
                cold_idx = IDX_W'(i);
                cold_any = 1'b1;
            end
        end
    end

    // Choose among the three tiers.
    always_comb begin
        if (inv_any)       victim = inv_idx;
        else if (cold_any) victim = cold_idx;
        else               victim = '0;
    end

endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation cache with per-entry permission, touched and
// modified marks. Lookup results are combinational; state changes on the next edge.
// Assumes: one lookup and one fill per cycle; fills only for pages that missed.
// Same-entry priority for the touched mark: fill > hit > use_clear.
// Valid: fill beats flush. Modified: fill clears, write hit sets.
module tlb_xlate #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 18,
    parameter int OFS_W   = 12,
    localparam int VA_W   = VPN_W + OFS_W,
    localparam int PA_W   = PFN_W + OFS_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_prot,
    output logic [IDX_W-1:0] fill_victim,
    output logic             evict_valid,
    output logic             evict_dirty,
    output logic [VPN_W-1:0] evict_vpn,
    input  logic             flush,
    input  logic             use_clear
);
    import tlb_pkg::*;

    localparam int EW = PROT_W + PFN_W;

    logic [VPN_W-1:0]        tag_q   [ENTRIES];
    logic [PFN_W-1:0]        pfn_q   [ENTRIES];
    tlb_prot_t               prot_q  [ENTRIES];
    logic [ENTRIES-1:0]      valid_q;
    logic [ENTRIES-1:0]      use_q;
    logic [ENTRIES-1:0]      dirty_q;

    logic [ENTRIES*VPN_W-1:0] tag_flat;
    logic [ENTRIES*EW-1:0]    ent_flat;
    logic [ENTRIES-1:0]       match_vec;
    logic [ENTRIES-1:0]       hit_vec;
    logic [EW-1:0]            sel_ent;
    tlb_prot_t                sel_prot;
    logic [PFN_W-1:0]         sel_pfn;
    logic                     any_match;
    logic                     permit;
    logic [VPN_W-1:0]         lk_vpn;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        // Pack per-entry storage for the comparator and the multiplexer.
        assign tag_flat[g*VPN_W +: VPN_W] = tag_q[g];
        assign ent_flat[g*EW +: EW]       = {prot_q[g], pfn_q[g]};
    end

    assign lk_vpn = lk_vaddr[OFS_W +: VPN_W];

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam (
        .tags_flat (tag_flat),
        .valid     (valid_q),
        .key       (lk_vpn),
        .match     (match_vec)
    );

    tlb_onehot_mux #(.ENTRIES(ENTRIES), .W(EW)) u_mux (
        .data_flat (ent_flat),
        .sel       (match_vec),
        .dout      (sel_ent)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid  (valid_q),
        .used   (use_q),
        .victim (fill_victim)
    );

    assign sel_prot = tlb_prot_t'(sel_ent[PFN_W +: PROT_W]);
    assign sel_pfn  = sel_ent[PFN_W-1:0];

    // Resolve the lookup outcome.
    always_comb begin
        any_match = |match_vec;
        permit    = tlb_permits(sel_prot, lk_write);
        lk_hit    = lk_valid && any_match && permit;
        lk_fault  = lk_valid && any_match && !permit;
        lk_miss   = lk_valid && !any_match;
        lk_paddr  = {sel_pfn, lk_vaddr[OFS_W-1:0]};
        hit_vec   = match_vec & {ENTRIES{lk_hit}};
    end

    // Report what the pending fill would displace.
    always_comb begin
        evict_valid = fill_valid && valid_q[fill_victim];
        evict_dirty = fill_valid && valid_q[fill_victim] && dirty_q[fill_victim];
        evict_vpn   = tag_q[fill_victim];
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic fill_here;
        assign fill_here = fill_valid && (fill_victim == IDX_W'(g));

        // Status marks of one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                use_q[g]   <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else begin
                if (fill_here)  valid_q[g] <= 1'b1;
                else if (flush) valid_q[g] <= 1'b0;

                if (fill_here)       use_q[g] <= 1'b1;
                else if (hit_vec[g]) use_q[g] <= 1'b1;
                else if (use_clear)  use_q[g] <= 1'b0;

                if (fill_here)                   dirty_q[g] <= 1'b0;
                else if (hit_vec[g] && lk_write) dirty_q[g] <= 1'b1;
            end
        end

        // Translation payload of one entry, written only by a fill.
        always_ff @(posedge clk) begin
            if (fill_here) begin
                tag_q[g]  <= fill_vpn;
                pfn_q[g]  <= fill_pfn;
                prot_q[g] <= tlb_prot_t'(fill_prot);
            end
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
// Property checker for tlb_xlate, attached by bind below.
// Assumes: sees the top's ports plus its match vector and status marks.
module tlb_xlate_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 18,
    parameter int OFS_W   = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lk_valid,
    input logic                     lk_write,
    input logic [VPN_W+OFS_W-1:0]   lk_vaddr,
    input logic                     lk_hit,
    input logic                     lk_miss,
    input logic                     lk_fault,
    input logic [PFN_W+OFS_W-1:0]   lk_paddr,
    input logic                     fill_valid,
    input logic                     evict_valid,
    input logic                     evict_dirty,
    input logic                     flush,
    input logic [ENTRIES-1:0]       match_vec,
    input logic [ENTRIES-1:0]       use_q,
    input logic [ENTRIES-1:0]       dirty_q
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit && !lk_miss && !lk_fault); // R2

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R1

    AST_FAULT_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault && !fill_valid |=> $stable(dirty_q)); // R4

    AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && lk_write && !fill_valid |=>
            (dirty_q & $past(match_vec)) == $past(match_vec)); // R5

    AST_HIT_MARKS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |=> (use_q & $past(match_vec)) == $past(match_vec)); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !fill_valid |=> !lk_hit && !lk_fault); // R9

    AST_EVICT_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |-> !evict_valid && !evict_dirty); // R11

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .OFS_W   (OFS_W)
) i_tlb_xlate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_write    (lk_write),
    .lk_vaddr    (lk_vaddr),
    .lk_hit      (lk_hit),
    .lk_miss     (lk_miss),
    .lk_fault    (lk_fault),
    .lk_paddr    (lk_paddr),
    .fill_valid  (fill_valid),
    .evict_valid (evict_valid),
    .evict_dirty (evict_dirty),
    .flush       (flush),
    .match_vec   (match_vec),
    .use_q       (use_q),
    .dirty_q     (dirty_q)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 16;
    localparam int VPN_W = 20;
    localparam int PFN_W = 18;
    localparam int OFS_W = 12;
    localparam int IDX_W = 4;

    typedef struct packed {
        logic        wr;
        logic [31:0] va;
        logic [2:0]  exp;   // {hit, miss, fault}
        logic [29:0] pa;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0001_0ABC, 3'b100, 30'h0010_0ABC},
        '{1'b1, 32'h0001_0FFF, 3'b100, 30'h0010_0FFF},
        '{1'b0, 32'h0002_0123, 3'b100, 30'h0020_0123},
        '{1'b1, 32'h0002_0000, 3'b001, 30'h0},
        '{1'b0, 32'h0003_0555, 3'b001, 30'h0},
        '{1'b1, 32'h0003_0555, 3'b100, 30'h0030_0555},
        '{1'b0, 32'h0004_0001, 3'b100, 30'h3FFF_F001},
        '{1'b1, 32'h0004_0001, 3'b001, 30'h0},
        '{1'b0, 32'h0005_0000, 3'b010, 30'h0},
        '{1'b0, 32'hFFFF_FFFF, 3'b010, 30'h0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lk_valid, lk_write;
    logic [31:0]      lk_vaddr;
    logic             lk_hit, lk_miss, lk_fault;
    logic [29:0]      lk_paddr;
    logic             fill_valid;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic [1:0]       fill_prot;
    logic [IDX_W-1:0] fill_victim;
    logic             evict_valid, evict_dirty;
    logic [VPN_W-1:0] evict_vpn;
    logic             flush, use_clear;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFS_W(OFS_W)) i_tlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_prot(fill_prot),
        .fill_victim(fill_victim), .evict_valid(evict_valid), .evict_dirty(evict_dirty),
        .evict_vpn(evict_vpn), .flush(flush), .use_clear(use_clear)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lk_valid = 0; lk_write = 0; lk_vaddr = '0;
        fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_prot = '0;
        flush = 0; use_clear = 0;
    endtask

    // Drive a lookup in the low phase, check flags, then take the edge.
    task automatic look(input string req, input logic wr, input logic [31:0] va,
                        input logic [2:0] exp, input logic [29:0] pa);
        @(negedge clk);
        lk_valid = 1; lk_write = wr; lk_vaddr = va;
        #1;
        chk(req, {lk_hit, lk_miss, lk_fault}, exp);
        if (exp[2]) chk(req, lk_paddr, pa);
        @(posedge clk); #1;
        idle();
    endtask

    // Present a fill and check the victim report; commit only if asked.
    task automatic fill(input string req, input logic commit, input logic [VPN_W-1:0] vpn,
                        input logic [PFN_W-1:0] pfn, input logic [1:0] prot,
                        input int exp_victim, input logic exp_ev, input logic exp_dirty,
                        input logic [VPN_W-1:0] exp_vpn);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot;
        #1;
        chk(req, fill_victim, exp_victim);
        chk(req, {evict_valid, evict_dirty}, {exp_ev, exp_dirty});
        if (exp_ev) chk(req, evict_vpn, exp_vpn);
        if (commit) begin
            @(posedge clk); #1;
        end
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // Reset state: all idle, a lookup misses, victim is slot 0 with nothing live (R2, R8, R11)
        @(negedge clk);
        chk("R2 idle after reset", {lk_hit, lk_miss, lk_fault}, 3'b000);
        look("R2 reset miss", 0, 32'h0001_0000, 3'b010, 0);
        fill("R11 reset probe", 0, 0, 0, 0, 0, 0, 0, 0);

        // Install four pages into invalid slots 0..3 (R8, R10)
        fill("R8 fill e0", 1, 20'h00010, 18'h00100, 2'b11, 0, 0, 0, 0);
        fill("R8 fill e1", 1, 20'h00020, 18'h00200, 2'b01, 1, 0, 0, 0);
        fill("R8 fill e2", 1, 20'h00030, 18'h00300, 2'b10, 2, 0, 0, 0);
        fill("R8 fill e3", 1, 20'h00040, 18'h3FFFF, 2'b01, 3, 0, 0, 0);

        // Table walk: hits, permission faults, misses (R1, R2, R3, R5)
        for (int i = 0; i < NVEC; i++)
            look($sformatf("R1/R3 vector %0d", i), VECS[i].wr, VECS[i].va, VECS[i].exp, VECS[i].pa);

        // Fill remaining slots; all valid and touched afterwards (R8, R10)
        for (int i = 4; i < ENTRIES; i++)
            fill("R8 fill rest", 1, 20'h00100 + 20'(i), 18'h01000 + 18'(i), 2'b11, i, 0, 0, 0);

        // All touched: fallback to slot 0, which was write-hit so modified (R5, R8, R11)
        fill("R5 dirty victim 0", 0, 0, 0, 0, 0, 1, 1, 20'h00010);

        // use_clear with a hit on entry 0 in the same cycle: entry 0 stays touched (R7)
        @(negedge clk);
        use_clear = 1; lk_valid = 1; lk_write = 0; lk_vaddr = 32'h0001_0000;
        #1;
        chk("R7 hit during clear", {lk_hit, lk_miss, lk_fault}, 3'b100);
        @(posedge clk); #1;
        idle();
        fill("R7 victim after clear", 0, 0, 0, 0, 1, 1, 0, 20'h00020);

        // Hits on entries 1 and 2, a write fault on entry 3 (R4, R6)
        look("R6 read hit e1", 0, 32'h0002_0000, 3'b100, 30'h0020_0000);
        look("R6 write hit e2", 1, 32'h0003_0000, 3'b100, 30'h0030_0000);
        look("R4 write fault e3", 1, 32'h0004_0000, 3'b001, 0);
        fill("R4 fault keeps marks", 0, 0, 0, 0, 3, 1, 0, 20'h00040);

        look("R6 read hit e3", 0, 32'h0004_0000, 3'b100, 30'h3FFF_F000);
        fill("R6 next cold slot", 0, 0, 0, 0, 4, 1, 0, 20'h00104);

        // Replace slot 4 (R10)
        fill("R10 replace slot 4", 1, 20'h00777, 18'h00777, 2'b01, 4, 1, 0, 20'h00104);
        look("R10 new page hits", 0, 32'h0077_7012, 3'b100, 30'h0077_7012);
        look("R10 old page gone", 0, 32'h0010_4000, 3'b010, 0);
        fill("R6 fill marks used", 0, 0, 0, 0, 5, 1, 0, 20'h00105);

        // Flush together with a fill: the fill survives (R9, R10)
        @(negedge clk);
        flush = 1; fill_valid = 1; fill_vpn = 20'h00888; fill_pfn = 18'h00888; fill_prot = 2'b11;
        #1;
        chk("R10 flush+fill victim", fill_victim, 5);
        @(posedge clk); #1;
        idle();
        look("R10 fill survives flush", 0, 32'h0088_80AA, 3'b100, 30'h0088_80AA);
        look("R9 old page flushed", 0, 32'h0001_0000, 3'b010, 0);
        fill("R11 victim invalid after flush", 0, 0, 0, 0, 0, 0, 0, 0);

        // Plain flush (R9)
        @(negedge clk); flush = 1;
        @(posedge clk); #1; idle();
        look("R9 flush empties", 0, 32'h0088_8000, 3'b010, 0);

        // No request: all flags low (R2)
        @(negedge clk);
        lk_valid = 0; lk_vaddr = 32'h0001_0000;
        #1;
        chk("R2 idle flags", {lk_hit, lk_miss, lk_fault}, 3'b000);
        idle();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule